// File: doc/BRIEF.md
# Ramp-Compare Bit-Serial Conversion Sequencer

This block is the shared, chip-level controller of an imager in which every pixel group owns only a one-bit comparator and a one-bit latch. A single threshold code drives a common DAC, and a single global data line is broadcast to all groups. For each output bit the sequencer sweeps the threshold upward across every quantisation step. Before each step it places on the data line the matching bit of the code that lies just below that threshold. Each group's latch keeps whatever the data line carries in the cycle its comparator first trips. One sweep therefore leaves one bit plane across the array. The plane is offered on a valid/ready handshake, and the sweep for the next bit waits until the plane has been taken.

Several sub-pixels share each comparator and are converted one after another. After all planes of one sub-pixel, the block spends one cycle on an autozero pulse: the selected sub-pixel is reset while the threshold output carries a fixed zeroing code. The thresholds come from a loadable table indexed by step number. The table resets to the identity, and loading it gives non-uniform transfer curves such as gamma. In this model the comparators are digital: a group trips when the threshold code is strictly greater than the stored level of its selected sub-pixel.

Top module: `rampPlaneSeq`

## Requirements
- R1: After reset, rampCode, bitX, pixReset, planeValid and busy are all 0.
- R2: During a sweep for plane bit k, the n-th cycle after the sweep starts shows rampCode equal to table entry n, for n from 1 to 2^CODE_W-1, and shows bitX equal to bit k of the binary code n-1.
- R3: In the cycle after the last step of a sweep, bitX equals bit k of the all-ones code, which is 1.
- R4: A group's plane bit is bit k of (t-1), where t is the first step whose table entry exceeds the group's selected level; if no entry exceeds the level, it is bit k of the all-ones code. With the identity table and a level below 2^CODE_W, the bit is bit k of the level.
- R5: Each sub-pixel yields exactly CODE_W planes, most significant bit first, and planeBit reports the bit index of the plane on offer.
- R6: planeValid rises after a sweep and stays high, with planeBits, planeBit and subSel unchanged, until a cycle with planeReady high. It drops in the following cycle, and no new sweep begins before that handshake.
- R7: After the last plane of a sub-pixel, pixReset is high for exactly one cycle. In that cycle rampCode equals AZ_CODE and subSel names the sub-pixel just converted.
- R8: A start pulse converts sub-pixels 0 to SUBS-1 in ascending order, with subSel naming the current one. busy is high from the cycle after start until the final autozero has finished.
- R9: A write of tblData to table entry tblAddr replaces the threshold used at that step in all later sweeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a full frame when idle |
| pixLevel | input | NUM_ADC*SUBS*DAC_W | Stored level per group and sub-pixel; field (sub*NUM_ADC+group) |
| tblWr | input | 1 | Threshold table write strobe |
| tblAddr | input | CODE_W | Table entry to write (step index) |
| tblData | input | DAC_W | DAC code for that step |
| rampCode | output | DAC_W | Global threshold code to the DAC |
| bitX | output | 1 | Global data line sampled by tripping latches |
| pixReset | output | 1 | Autozero/reset pulse for the selected sub-pixel |
| subSel | output | SUB_W | Sub-pixel currently converted |
| planeValid | output | 1 | A bit plane is on offer |
| planeReady | input | 1 | Consumer accepts the plane |
| planeBits | output | NUM_ADC | Bit plane, one bit per group |
| planeBit | output | BIT_W | Bit index of the plane on offer |
| busy | output | 1 | Frame in progress |

## Verification
The bench targets levels at the ends of the scale. A level of 0 trips on the very first step, and a design that sampled bitX one step late would report code 1 for it. A level at or above the top threshold never trips, so a design that skipped the closing all-ones capture would keep stale bits for it. The bench stalls the ready line and checks the offered plane, which catches a design that overwrites or withdraws the plane under back-pressure. It also loads a gamma table; a design that ignored the table would still quantise linearly and miscode the mid-range levels. Finally it checks that the autozero pulse names the sub-pixel just finished, which exposes a design that advances the sub-pixel select before the reset cycle.

// File: rtl/rampPlanePkg.sv
package rampPlanePkg;
  typedef struct packed {
    logic clr;   // clear trip flags before a sweep
    logic step;  // present one threshold step
    logic fin;   // close the sweep with the all-ones bit
    logic az;    // autozero cycle
    logic ack;   // plane handshake taken
  } seqStrobe_t;
endpackage

// File: rtl/pixLatchCell.sv
module pixLatchCell #(
  parameter int DAC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             evalEn,
  input  logic             finEn,
  input  logic [DAC_W-1:0] rampCode,
  input  logic [DAC_W-1:0] level,
  input  logic             bitX,
  output logic             bitQ
);
  logic tripped;
  logic cmpHit;

  // behavioural comparator: flips once ramp passes the stored level
  assign cmpHit = evalEn && (rampCode > level) && !tripped;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tripped <= 1'b0;
      bitQ    <= 1'b0;
    end else if (clr) begin
      tripped <= 1'b0;
    end else if (cmpHit || (finEn && !tripped)) begin
      bitQ    <= bitX;
      tripped <= 1'b1;
    end
  end
endmodule

// File: rtl/pixSeqCtrl.sv
module pixSeqCtrl
  import rampPlanePkg::*;
#(
  parameter int CODE_W = 3,
  parameter int SUBS   = 4,
  localparam int BIT_W = $clog2(CODE_W),
  localparam int SUB_W = $clog2(SUBS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              planeValid,
  input  logic              planeReady,
  output seqStrobe_t        stb,
  output logic [CODE_W-1:0] stepIdx,
  output logic [BIT_W-1:0]  bitIdx,
  output logic [SUB_W-1:0]  subIdx,
  output logic              busy
);
  localparam logic [CODE_W-1:0] LAST_STEP = {CODE_W{1'b1}};
  localparam logic [BIT_W-1:0]  TOP_BIT   = BIT_W'(CODE_W - 1);
  localparam logic [SUB_W-1:0]  LAST_SUB  = SUB_W'(SUBS - 1);

  typedef enum logic [2:0] {S_IDLE, S_SWEEP, S_FINAL, S_HOLD, S_ZERO, S_NEXT} seqState_e;
  seqState_e state;

  logic handshake;
  assign handshake = planeValid && planeReady;
  assign busy      = (state != S_IDLE);

  always_comb begin
    stb = '0;
    case (state)
      S_IDLE:  stb.clr = start;
      S_SWEEP: stb.step = 1'b1;
      S_FINAL: stb.fin = 1'b1;
      S_HOLD: begin
        stb.ack = handshake;
        stb.clr = handshake && (bitIdx != '0);
      end
      S_ZERO:  stb.az = 1'b1;
      S_NEXT:  stb.clr = (subIdx != LAST_SUB);
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepIdx <= '0;
      bitIdx  <= '0;
      subIdx  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_SWEEP;
          stepIdx <= CODE_W'(1);
          bitIdx  <= TOP_BIT;
          subIdx  <= '0;
        end
        S_SWEEP: begin
          if (stepIdx == LAST_STEP) state <= S_FINAL;
          else stepIdx <= stepIdx + 1'b1;
        end
        S_FINAL: state <= S_HOLD;
        S_HOLD: if (handshake) begin
          if (bitIdx != '0) begin
            bitIdx  <= bitIdx - 1'b1;
            stepIdx <= CODE_W'(1);
            state   <= S_SWEEP;
          end else begin
            state <= S_ZERO;
          end
        end
        S_ZERO: state <= S_NEXT;
        S_NEXT: begin
          if (subIdx == LAST_SUB) begin
            state <= S_IDLE;
          end else begin
            subIdx  <= subIdx + 1'b1;
            bitIdx  <= TOP_BIT;
            stepIdx <= CODE_W'(1);
            state   <= S_SWEEP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pixPlaneDp.sv
module pixPlaneDp
  import rampPlanePkg::*;
#(
  parameter int NUM_ADC = 4,
  parameter int SUBS    = 4,
  parameter int CODE_W  = 3,
  parameter int DAC_W   = 6,
  parameter logic [DAC_W-1:0] AZ_CODE = DAC_W'(32),
  localparam int BIT_W = $clog2(CODE_W),
  localparam int SUB_W = $clog2(SUBS),
  localparam int TBL_N = 1 << CODE_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobe_t                    stb,
  input  logic [CODE_W-1:0]             stepIdx,
  input  logic [BIT_W-1:0]              bitIdx,
  input  logic [SUB_W-1:0]              subIdx,
  input  logic [NUM_ADC*SUBS*DAC_W-1:0] pixLevel,
  input  logic                          tblWr,
  input  logic [CODE_W-1:0]             tblAddr,
  input  logic [DAC_W-1:0]              tblData,
  output logic [DAC_W-1:0]              rampCode,
  output logic                          bitX,
  output logic                          pixReset,
  output logic                          planeValid,
  output logic [NUM_ADC-1:0]            planeBits
);
  logic [DAC_W-1:0]  thrTbl [TBL_N];
  logic [CODE_W-1:0] prevCode;
  logic              evalEn;
  logic              finEn;

  assign prevCode = stepIdx - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_N; i++) thrTbl[i] <= DAC_W'(i);
    end else if (tblWr) begin
      thrTbl[tblAddr] <= tblData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rampCode   <= '0;
      bitX       <= 1'b0;
      evalEn     <= 1'b0;
      finEn      <= 1'b0;
      pixReset   <= 1'b0;
      planeValid <= 1'b0;
    end else begin
      evalEn   <= stb.step;
      finEn    <= stb.fin;
      pixReset <= stb.az;
      if (stb.step) begin
        rampCode <= thrTbl[stepIdx];
        bitX     <= prevCode[bitIdx];
      end else if (stb.fin) begin
        bitX <= 1'b1;  // bit of the all-ones code
      end else if (stb.az) begin
        rampCode <= AZ_CODE;
      end
      if (finEn)        planeValid <= 1'b1;
      else if (stb.ack) planeValid <= 1'b0;
    end
  end

  for (genvar a = 0; a < NUM_ADC; a++) begin : g_cell
    logic [DAC_W-1:0] selLevel;
    assign selLevel = pixLevel[(int'(subIdx) * NUM_ADC + a) * DAC_W +: DAC_W];
    pixLatchCell #(.DAC_W(DAC_W)) u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .clr      (stb.clr),
      .evalEn   (evalEn),
      .finEn    (finEn),
      .rampCode (rampCode),
      .level    (selLevel),
      .bitX     (bitX),
      .bitQ     (planeBits[a])
    );
  end
endmodule

// File: rtl/rampPlaneSeq.sv
module rampPlaneSeq
  import rampPlanePkg::*;
#(
  parameter int NUM_ADC = 4,
  parameter int SUBS    = 4,
  parameter int CODE_W  = 3,
  parameter int DAC_W   = 6,
  parameter logic [DAC_W-1:0] AZ_CODE = DAC_W'(32),
  localparam int BIT_W = $clog2(CODE_W),
  localparam int SUB_W = $clog2(SUBS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [NUM_ADC*SUBS*DAC_W-1:0] pixLevel,
  input  logic                          tblWr,
  input  logic [CODE_W-1:0]             tblAddr,
  input  logic [DAC_W-1:0]              tblData,
  output logic [DAC_W-1:0]              rampCode,
  output logic                          bitX,
  output logic                          pixReset,
  output logic [SUB_W-1:0]              subSel,
  output logic                          planeValid,
  input  logic                          planeReady,
  output logic [NUM_ADC-1:0]            planeBits,
  output logic [BIT_W-1:0]              planeBit,
  output logic                          busy
);
  seqStrobe_t        stb;
  logic [CODE_W-1:0] stepIdx;

  pixSeqCtrl #(.CODE_W(CODE_W), .SUBS(SUBS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .planeValid (planeValid),
    .planeReady (planeReady),
    .stb        (stb),
    .stepIdx    (stepIdx),
    .bitIdx     (planeBit),
    .subIdx     (subSel),
    .busy       (busy)
  );

  pixPlaneDp #(
    .NUM_ADC(NUM_ADC), .SUBS(SUBS), .CODE_W(CODE_W), .DAC_W(DAC_W), .AZ_CODE(AZ_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .stepIdx    (stepIdx),
    .bitIdx     (planeBit),
    .subIdx     (subSel),
    .pixLevel   (pixLevel),
    .tblWr      (tblWr),
    .tblAddr    (tblAddr),
    .tblData    (tblData),
    .rampCode   (rampCode),
    .bitX       (bitX),
    .pixReset   (pixReset),
    .planeValid (planeValid),
    .planeBits  (planeBits)
  );
endmodule

// File: rtl/rampPlaneSeqChecker.sv
module rampPlaneSeqChecker #(
  parameter int NUM_ADC = 4,
  parameter int CODE_W  = 3,
  parameter int DAC_W   = 6,
  parameter int BIT_W   = 2,
  parameter int SUB_W   = 2,
  parameter logic [DAC_W-1:0] AZ_CODE = DAC_W'(32)
) (
  input logic               clk,
  input logic               rstN,
  input logic               planeValid,
  input logic               planeReady,
  input logic [NUM_ADC-1:0] planeBits,
  input logic [BIT_W-1:0]   planeBit,
  input logic [SUB_W-1:0]   subSel,
  input logic               pixReset,
  input logic [DAC_W-1:0]   rampCode,
  input logic               busy
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!planeValid && !pixReset));

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (planeValid && !planeReady) |=> (planeValid && $stable(planeBits)));

  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (planeValid && planeReady) |=> !planeValid);

  p_plane_tag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (planeValid && !planeReady) |=> ($stable(planeBit) && $stable(subSel)));

  p_az_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    pixReset |-> (rampCode == AZ_CODE));

  p_az_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    pixReset |=> !pixReset);

  p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rstN)
    (planeValid || pixReset) |-> busy);
endmodule

bind rampPlaneSeq rampPlaneSeqChecker #(
  .NUM_ADC(NUM_ADC), .CODE_W(CODE_W), .DAC_W(DAC_W),
  .BIT_W(BIT_W), .SUB_W(SUB_W), .AZ_CODE(AZ_CODE)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .planeValid (planeValid),
  .planeReady (planeReady),
  .planeBits  (planeBits),
  .planeBit   (planeBit),
  .subSel     (subSel),
  .pixReset   (pixReset),
  .rampCode   (rampCode),
  .busy       (busy)
);

// File: tb/rampPlaneSeq_bench.sv
`timescale 1ns/1ps
module rampPlaneSeq_bench;
  localparam int NUM_ADC = 4;
  localparam int SUBS    = 4;
  localparam int CODE_W  = 3;
  localparam int DAC_W   = 6;
  localparam int AZ      = 32;
  localparam int BIT_W   = $clog2(CODE_W);
  localparam int SUB_W   = $clog2(SUBS);
  localparam int MAXT    = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NUM_ADC*SUBS*DAC_W-1:0] pixLevel = '0;
  logic tblWr = 1'b0;
  logic [CODE_W-1:0] tblAddr = '0;
  logic [DAC_W-1:0] tblData = '0;
  logic [DAC_W-1:0] rampCode;
  logic bitX, pixReset, planeValid, busy;
  logic planeReady = 1'b1;
  logic [SUB_W-1:0] subSel;
  logic [NUM_ADC-1:0] planeBits;
  logic [BIT_W-1:0] planeBit;

  always #2.5 clk = ~clk;

  rampPlaneSeq #(
    .NUM_ADC(NUM_ADC), .SUBS(SUBS), .CODE_W(CODE_W), .DAC_W(DAC_W), .AZ_CODE(DAC_W'(AZ))
  ) u_rampPlaneSeq (.*);

  int nVec = 0;
  int nBad = 0;
  int refTbl [MAXT+1];
  int lv [SUBS][NUM_ADC];
  int qSub[$], qBit[$], qBits[$], qAz[$];
  bit stallMode = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int codeOf(input int v);
    for (int t = 1; t <= MAXT; t++) if (refTbl[t] > v) return t - 1;
    return MAXT;
  endfunction

  // scoreboard monitor for bit planes
  initial begin
    forever begin
      @(negedge clk);
      if (planeValid) begin
        automatic int snap = planeBits;
        if (stallMode) begin
          for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(planeValid && planeBits == snap, "R6 hold under stall", int'(planeBits), snap);
          end
          planeReady = 1'b1;
        end
        if (qSub.size() == 0) begin
          check(1'b0, "R5 unexpected plane", 1, 0);
        end else begin
          automatic int eS = qSub.pop_front();
          automatic int eB = qBit.pop_front();
          automatic int eV = qBits.pop_front();
          check(int'(subSel) == eS, "R8 plane sub-pixel", int'(subSel), eS);
          check(int'(planeBit) == eB, "R5 plane bit index", int'(planeBit), eB);
          check(int'(planeBits) == eV, "R4 plane contents", int'(planeBits), eV);
        end
        @(negedge clk);
        check(!planeValid, "R6 valid drops after handshake", int'(planeValid), 0);
        if (stallMode) planeReady = 1'b0;
      end
    end
  end

  // autozero monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pixReset) begin
        automatic int eS = (qAz.size() != 0) ? qAz.pop_front() : -1;
        check(int'(subSel) == eS, "R7 autozero sub-pixel", int'(subSel), eS);
        check(int'(rampCode) == AZ, "R7 autozero ramp code", int'(rampCode), AZ);
      end
    end
  end

  task automatic loadEntry(input int addr, input int val);
    @(negedge clk);
    tblWr = 1'b1; tblAddr = CODE_W'(addr); tblData = DAC_W'(val);
    @(negedge clk);
    tblWr = 1'b0;
    refTbl[addr] = val;
  endtask

  task automatic runFrame(input bit doTrace);
    for (int s = 0; s < SUBS; s++) begin
      for (int a = 0; a < NUM_ADC; a++)
        pixLevel[(s*NUM_ADC + a)*DAC_W +: DAC_W] = DAC_W'(lv[s][a]);
      for (int k = CODE_W - 1; k >= 0; k--) begin
        automatic int bits = 0;
        for (int a = 0; a < NUM_ADC; a++) bits |= ((codeOf(lv[s][a]) >> k) & 1) << a;
        qSub.push_back(s); qBit.push_back(k); qBits.push_back(bits);
      end
      qAz.push_back(s);
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R8 busy after start", int'(busy), 1);
    if (doTrace) begin
      for (int t = 1; t <= MAXT; t++) begin
        @(negedge clk);
        check(int'(rampCode) == refTbl[t], "R2 ramp step code", int'(rampCode), refTbl[t]);
        check(int'(bitX) == (((t - 1) >> (CODE_W - 1)) & 1), "R2 data line per step",
              int'(bitX), ((t - 1) >> (CODE_W - 1)) & 1);
      end
      @(negedge clk);
      check(bitX == 1'b1, "R3 closing all-ones bit", int'(bitX), 1);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(qSub.size() == 0, "R5 planes per frame", qSub.size(), 0);
    check(qAz.size() == 0, "R8 autozero per sub-pixel", qAz.size(), 0);
    check(!planeValid && !pixReset, "R8 quiet when done", int'(planeValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    for (int t = 0; t <= MAXT; t++) refTbl[t] = t;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(rampCode == '0 && bitX == 1'b0, "R1 ramp and data line", int'(rampCode), 0);
    check(!planeValid && !pixReset && !busy, "R1 control outputs", int'(busy), 0);
    rstN = 1'b1;

    // identity table, boundary levels 0 and above range (R2, R3, R4)
    for (int s = 0; s < SUBS; s++)
      for (int a = 0; a < NUM_ADC; a++) lv[s][a] = (s * 5 + a * 3) % 9;
    lv[0][0] = 0; lv[0][1] = 7; lv[0][2] = 40; lv[0][3] = 6;
    runFrame(1'b1);

    // back-pressure on the plane handshake (R6)
    stallMode = 1'b1;
    planeReady = 1'b0;
    for (int s = 0; s < SUBS; s++)
      for (int a = 0; a < NUM_ADC; a++) lv[s][a] = (s + 2 * a + 1) % 8;
    runFrame(1'b0);
    stallMode = 1'b0;
    planeReady = 1'b1;

    // gamma table (R9): entry t becomes t*t
    for (int t = 1; t <= MAXT; t++) loadEntry(t, t * t);
    lv[0][0] = 0;  lv[0][1] = 3;  lv[0][2] = 4;  lv[0][3] = 48;
    lv[1][0] = 49; lv[1][1] = 60; lv[1][2] = 9;  lv[1][3] = 15;
    lv[2][0] = 16; lv[2][1] = 24; lv[2][2] = 25; lv[2][3] = 35;
    lv[3][0] = 36; lv[3][1] = 1;  lv[3][2] = 8;  lv[3][3] = 63;
    runFrame(1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule